// File: doc/BRIEF.md
# SPI Event to Pulse-Pair Encoder

This block sits on the master end of a transformer-isolated two-wire link. It watches the local SPI chip-select, clock and data-in lines and turns each communication event into a symmetric pulse pair. The pair is driven through two switch enables, one for positive drive and one for negative drive. Each pair has equal positive and negative halves, so the line never carries a DC level or a clock. A falling or rising chip-select is sent with long halves. A data bit, sampled on the SPI clock rising edge, is sent with short halves. Polarity tells the two chip-select edges apart and gives the data bit's value.

The SPI lines are asynchronous to the block clock, so each one passes through a two-flop synchronizer first. Events that arrive while a pair is still on the line wait in a small FIFO and go out in arrival order. Between two pairs the line always returns to idle, with both switches open, for at least one cycle. A busy flag tells the surrounding logic that traffic is still pending on the link.

Top module: `spi_pulse_encoder`

## Requirements
- R1: A synchronous active-low reset, even one applied while a pair is on the line, leaves both drive enables low, busy low and the event queue empty. After the reset is released, no pulse appears until a new SPI event arrives.
- R2: A chip-select falling edge (cs_n 1 to 0) is sent as a -1 pair: drv_neg high for HALF_LONG cycles (default 40), then drv_pos high for HALF_LONG cycles.
- R3: A chip-select rising edge (cs_n 0 to 1) is sent as a +1 pair: drv_pos high for HALF_LONG cycles, then drv_neg high for HALF_LONG cycles.
- R4: On an SCK rising edge while cs_n is low, SDI is sampled. A 1 is sent as a +1 pair and a 0 as a -1 pair, each half lasting HALF_SHORT cycles (default 25).
- R5: An SCK rising edge while cs_n is high produces no pulse, and busy stays low.
- R6: drv_pos and drv_neg are never high in the same cycle.
- R7: After the second half of any pair, both drive enables are low for at least one cycle before the next pair starts.
- R8: Events that arrive while a pair is in flight are held in a FIFO of DEPTH entries (default 4) and sent in arrival order.
- R9: busy is high while a pair is on the line or an event is queued. It falls once the line is idle and the queue is empty, and both drive enables are low whenever busy is low.
- R10: The first half of a pair starts no more than 6 clock cycles after the SPI edge that caused it, provided the queue and line were idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all timing counts are in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Local SPI chip-select, active low, asynchronous |
| sck | input | 1 | Local SPI clock, asynchronous |
| sdi | input | 1 | Local SPI data toward the far side, asynchronous |
| drv_pos | output | 1 | Enable for positive differential drive |
| drv_neg | output | 1 | Enable for negative differential drive |
| busy | output | 1 | A pair is on the line or an event is queued |

## Verification
Several properties are checked in every cycle: the two drive enables are never high together, an idle cycle always follows the end of a second half, the queue is never written when full, and the line is idle whenever busy is low. The pulse widths, the polarity chosen for each event class and SDI value, the arrival-order draining of queued events, the start latency, the clock edges ignored outside a frame, and recovery from a reset in mid-pulse can only be shown by the bench's scenarios. The bench measures those from the drive enables alone.

// File: rtl/spe_pkg.sv
// Shared types for the SPI event to pulse-pair encoder.
// Assumes: one event class flag and one polarity flag describe every pair.
package spe_pkg;

    // One queued line event: half-width class and polarity of its first half.
    typedef struct packed {
        logic long_w;   // 1: chip-select edge (long halves), 0: data bit (short halves)
        logic plus;     // 1: +1 pair (positive first), 0: -1 pair (negative first)
    } spe_evt_t;

    // Pulse shaper phase.
    typedef enum logic [1:0] {
        SH_IDLE   = 2'd0,
        SH_FIRST  = 2'd1,
        SH_SECOND = 2'd2
    } spe_phase_t;

endpackage

// File: rtl/spe_edge_detect.sv
// Synchronizes the asynchronous SPI lines and turns their edges into events.
// Assumes: the SPI lines are stable for at least two block clock cycles
// between changes, and SDI is settled at least one cycle before the SCK rise.
// At most one event is produced per cycle.
module spe_edge_detect
    import spe_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_n,
    input  logic     sck,
    input  logic     sdi,
    output logic     evt_valid,
    output spe_evt_t evt
);

    logic cs_m, cs_s, cs_q;
    logic sck_m, sck_s, sck_q;
    logic sdi_m, sdi_s;
    logic cs_fall, cs_rise, sck_rise;

    // Two-flop synchronizers plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_m  <= 1'b1;
            cs_s  <= 1'b1;
            cs_q  <= 1'b1;
            sck_m <= 1'b0;
            sck_s <= 1'b0;
            sck_q <= 1'b0;
            sdi_m <= 1'b0;
            sdi_s <= 1'b0;
        end else begin
            cs_m  <= cs_n;
            cs_s  <= cs_m;
            cs_q  <= cs_s;
            sck_m <= sck;
            sck_s <= sck_m;
            sck_q <= sck_s;
            sdi_m <= sdi;
            sdi_s <= sdi_m;
        end
    end

    // Event classification; a clock edge counts only inside a settled frame.
    always_comb begin
        cs_fall   = cs_q & ~cs_s;
        cs_rise   = ~cs_q & cs_s;
        sck_rise  = ~sck_q & sck_s & ~cs_s & ~cs_q;
        evt_valid = cs_fall | cs_rise | sck_rise;
        evt.long_w = cs_fall | cs_rise;
        evt.plus   = (cs_fall | cs_rise) ? cs_rise : sdi_s;
    end

endmodule

// File: rtl/spe_event_fifo.sv
// Small FIFO holding line events in arrival order.
// Assumes: DEPTH is a power of two; a push while full is dropped, and
// the sender is expected never to do that.
module spe_event_fifo
    import spe_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  spe_evt_t wr_data,
    input  logic     pop,
    output spe_evt_t rd_data,
    output logic     empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    spe_evt_t       mem [DEPTH];
    logic [AW:0]    wr_ptr, rd_ptr;
    logic           full;

    // Status from pointer comparison with a wrap bit.
    always_comb begin
        empty   = (wr_ptr == rd_ptr);
        full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
        rd_data = mem[rd_ptr[AW-1:0]];
    end

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (push && !full) mem[wr_ptr[AW-1:0]] <= wr_data;
    end

    // Pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push && !full) wr_ptr <= wr_ptr + 1'b1;
            if (pop && !empty) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R8

endmodule

// File: rtl/spe_pulse_shaper.sv
// Times the two halves of each pair and drives the switch enables.
// Assumes: HALF_LONG and HALF_SHORT are at least 1. Each pair occupies
// 2*half cycles, followed by at least one idle cycle spent loading the next event.
module spe_pulse_shaper
    import spe_pkg::*;
#(
    parameter int HALF_LONG  = 40,
    parameter int HALF_SHORT = 25
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     evt_avail,
    input  spe_evt_t evt_in,
    output logic     pop,
    output logic     drv_pos,
    output logic     drv_neg,
    output logic     active
);

    localparam int MAXH = (HALF_LONG > HALF_SHORT) ? HALF_LONG : HALF_SHORT;
    localparam int CW   = $clog2(MAXH + 1);
    localparam logic [CW-1:0] LOAD_L = CW'(HALF_LONG - 1);
    localparam logic [CW-1:0] LOAD_S = CW'(HALF_SHORT - 1);

    spe_phase_t    phase;
    spe_evt_t      cur;
    logic [CW-1:0] cnt;

    // Fetch only from idle, which guarantees an idle cycle between pairs.
    always_comb begin
        pop     = (phase == SH_IDLE) && evt_avail;
        active  = (phase != SH_IDLE);
        drv_pos = ((phase == SH_FIRST) && cur.plus) || ((phase == SH_SECOND) && !cur.plus);
        drv_neg = ((phase == SH_FIRST) && !cur.plus) || ((phase == SH_SECOND) && cur.plus);
    end

    // Phase sequencer and half-width down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= SH_IDLE;
            cur   <= '0;
            cnt   <= '0;
        end else begin
            case (phase)
                SH_IDLE: begin
                    if (evt_avail) begin
                        cur   <= evt_in;
                        cnt   <= evt_in.long_w ? LOAD_L : LOAD_S;
                        phase <= SH_FIRST;
                    end
                end
                SH_FIRST: begin
                    if (cnt == '0) begin
                        cnt   <= cur.long_w ? LOAD_L : LOAD_S;
                        phase <= SH_SECOND;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SH_SECOND: begin
                    if (cnt == '0) phase <= SH_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: phase <= SH_IDLE;
            endcase
        end
    end

    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_pos && drv_neg)); // R6

    AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == SH_SECOND && cnt == '0) |=> (!drv_pos && !drv_neg)); // R7

endmodule

// File: rtl/spi_pulse_encoder.sv
// Top: SPI events in, DC-free tri-level pulse pairs out on two switch enables.
// Assumes: SPI traffic is slow enough that no more than DEPTH events wait
// at once (one SPI bit takes far longer than one short pair at nominal rates).
module spi_pulse_encoder
    import spe_pkg::*;
#(
    parameter int HALF_LONG  = 40,
    parameter int HALF_SHORT = 25,
    parameter int DEPTH      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic sdi,
    output logic drv_pos,
    output logic drv_neg,
    output logic busy
);

    logic     evt_valid, pop, empty, active;
    spe_evt_t evt, head;

    spe_edge_detect u_edge (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .evt_valid(evt_valid), .evt(evt)
    );

    spe_event_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(evt_valid), .wr_data(evt),
        .pop(pop), .rd_data(head), .empty(empty)
    );

    spe_pulse_shaper #(.HALF_LONG(HALF_LONG), .HALF_SHORT(HALF_SHORT)) u_shape (
        .clk(clk), .rst_n(rst_n), .evt_avail(!empty), .evt_in(head),
        .pop(pop), .drv_pos(drv_pos), .drv_neg(drv_neg), .active(active)
    );

    // Pending traffic: line active or events waiting.
    always_comb busy = active || !empty;

    AST_QUIET_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!drv_pos && !drv_neg)); // R9

endmodule

// File: tb/sim_spi_pulse_encoder.sv
module sim_spi_pulse_encoder;

    localparam int HL = 40;
    localparam int HS = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic drv_pos, drv_neg, busy;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    spi_pulse_encoder #(.HALF_LONG(HL), .HALF_SHORT(HS), .DEPTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .drv_pos(drv_pos), .drv_neg(drv_neg), .busy(busy)
    );

    // Vector table: action (0 cs fall, 1 cs rise, 2 data bit), sdi, expected +1, half length
    localparam int NV = 6;
    localparam logic [1:0] V_ACT  [NV] = '{2'd0, 2'd2, 2'd2, 2'd2, 2'd2, 2'd1};
    localparam logic       V_SDI  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic       V_PLUS [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam int         V_LEN  [NV] = '{HL, HS, HS, HS, HS, HL};

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Continuous check of both-sides drive at every sample point.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && drv_pos && drv_neg) check(1'b0, "R6 both enables high", 1, 0);
        end
    end

    // Wait for the next pair and check its halves and the idle cycle after it.
    task automatic measure_pair(input bit exp_plus, input int exp_len, input string tag,
                                output int lat);
        logic [1:0] lvl1, lvl2, want1;
        int n1, n2;
        lat = 0;
        while (!drv_pos && !drv_neg && lat < 200) begin cyc(); lat++; end
        want1 = exp_plus ? 2'b10 : 2'b01;
        lvl1 = {drv_pos, drv_neg};
        check(lvl1 == want1, {tag, " first half level"}, int'(lvl1), int'(want1));
        n1 = 0;
        while ({drv_pos, drv_neg} == lvl1 && n1 < 300) begin cyc(); n1++; end
        check(n1 == exp_len, {tag, " first half length"}, n1, exp_len);
        lvl2 = {drv_pos, drv_neg};
        check(lvl2 == ~want1, {tag, " second half level"}, int'(lvl2), int'(~want1));
        n2 = 0;
        while ({drv_pos, drv_neg} == lvl2 && n2 < 300) begin cyc(); n2++; end
        check(n2 == exp_len, {tag, " second half length"}, n2, exp_len);
        check(!drv_pos && !drv_neg, "R7 idle after pair", int'({drv_pos, drv_neg}), 0);
    endtask

    initial begin
        int lat;
        int quiet;
        logic busy_mid;

        // R1: reset state
        cyc(3);
        check(!drv_pos && !drv_neg && !busy, "R1 reset state", int'({drv_pos, drv_neg, busy}), 0);
        rst_n = 1'b1;
        cyc(10);
        check(!drv_pos && !drv_neg && !busy, "R1 idle after release", int'({drv_pos, drv_neg, busy}), 0);

        // Table walk: one frame of events, each pair measured on its own.
        for (int i = 0; i < NV; i++) begin
            case (V_ACT[i])
                2'd0: cs_n = 1'b0;
                2'd1: cs_n = 1'b1;
                default: begin
                    sdi = V_SDI[i];
                    cyc(2);
                    sck = 1'b1;
                end
            endcase
            measure_pair(V_PLUS[i], V_LEN[i],
                         (V_ACT[i] == 2'd0) ? "R2 cs fall" :
                         (V_ACT[i] == 2'd1) ? "R3 cs rise" : "R4 data bit", lat);
            check(lat <= 6, "R10 start latency", lat, 6);
            check(!busy, "R9 busy low after single pair", int'(busy), 0);
            sck = 1'b0;
            cyc(5);
        end

        // R5: clock edges outside a frame are ignored.
        quiet = 0;
        for (int k = 0; k < 4; k++) begin
            sdi = k[0];
            sck = 1'b1;
            for (int j = 0; j < 10; j++) begin cyc(); if (drv_pos || drv_neg || busy) quiet++; end
            sck = 1'b0;
            for (int j = 0; j < 10; j++) begin cyc(); if (drv_pos || drv_neg || busy) quiet++; end
        end
        check(quiet == 0, "R5 sck outside frame", quiet, 0);

        // R8/R9: a burst of three events is queued and drained in order.
        sdi = 1'b1;
        fork
            begin
                cs_n = 1'b0;
                cyc(4);
                sck = 1'b1;
                cyc(4);
                sck = 1'b0;
                sdi = 1'b0;
                cyc(4);
                sck = 1'b1;
                cyc(4);
                sck = 1'b0;
            end
        join_none
        measure_pair(1'b0, HL, "R8 queued cs fall", lat);
        busy_mid = busy;
        check(busy_mid, "R9 busy with queued events", int'(busy_mid), 1);
        measure_pair(1'b1, HS, "R8 queued bit 1", lat);
        measure_pair(1'b0, HS, "R8 queued bit 0", lat);
        cyc();
        check(!busy, "R9 busy falls after drain", int'(busy), 0);

        // R1: reset during a pair.
        cs_n = 1'b1;
        cyc(6);
        check(drv_pos && busy, "R1 pair started before reset", int'({drv_pos, busy}), 3);
        cyc(10);
        rst_n = 1'b0;
        cyc();
        check(!drv_pos && !drv_neg && !busy, "R1 reset mid-pulse", int'({drv_pos, drv_neg, busy}), 0);
        cyc(3);
        rst_n = 1'b1;
        quiet = 0;
        for (int j = 0; j < 100; j++) begin cyc(); if (drv_pos || drv_neg || busy) quiet++; end
        check(quiet == 0, "R1 quiet after reset", quiet, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule